// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block watches a memory controller through a vector of one-cycle event strobes and keeps four counters. Counter 0 counts clock cycles and acts as the timebase for the whole unit. Counters 1 to 3 each follow one event. An 8-bit select code in the counter's control register picks which strobe line that counter adds up. Software reaches the unit through a simple register port: one control register and one read-only count register per counter.

The cycle counter governs the others. While it is disabled or frozen, no counter moves. When it wraps, every counter stops and the single interrupt line goes high. The interrupt is released when software writes zero to counter 0's control register. Counters 1 to 3 wrap silently and only set their own overflow flag. Once counter 0 is running, a new write that sets its enable is ignored. To restart it, software must disable it first, then enable it again with the clear bit set.

Top module: `mc_event_counter`

## Requirements
- R1: After reset, every control register and every count reads as zero, and `irq` is low.
- R2: Control register n is at byte address 4*n and count n at 0x20 + 4*n, for n from 0 to 3. Every other address reads as zero. In a control register, bit 0 is the overflow flag (read-only), bit 1 is the clear command (always reads 0), bit 2 is the enable and bits 31:24 are the select code. All other bits read 0. Read data appears on `rdData` one cycle after `rdEn`, showing the state before that edge.
- R3: While counter 0 is enabled and its overflow flag is clear, it adds one every cycle, whatever its select code.
- R4: Counter n (1 to 3) adds one in each cycle in which all of these hold: its enable is set, counter 0 is running, and `evtStrobe[sel]` is high. A select code of 0 or of NUM_EVT or above never counts.
- R5: When counter 1, 2 or 3 wraps from all ones to zero, it sets its own overflow flag and keeps counting. `irq` does not change.
- R6: When counter 0 wraps, it goes to zero and sets its overflow flag, and `irq` rises. From the next cycle on, all four counters hold until the flag is cleared.
- R7: While counter 0 is disabled, no counter changes.
- R8: A control write with bit 1 set zeroes that counter and its overflow flag at the write edge. This takes priority over an increment or a wrap in the same cycle. A control write with bit 2 clear also clears the overflow flag.
- R9: A write to counter 0's control register that sets bit 2 while counter 0 is already enabled has no effect. Writing zero to that register lowers `irq`. A later write of enable with clear restarts all counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after `rdEn` |
| evtStrobe | input | NUM_EVT | Per-cycle event strobes, indexed by select code |
| irq | output | 1 | High while counter 0's overflow flag is set |

## Verification
The sharp collisions are a control write meeting a count update in the same edge. One case is a clear landing on a counter that is incrementing, or that is at all ones and about to wrap. The other is a write of zero to counter 0 landing in the cycle its wrap would freeze the unit. A directed sequence steers counter 1 to all ones with its strobe held high, then issues the clear in exactly that cycle. The expected result is a zero count and a clear overflow flag. Long random runs mix writes, reads and strobes so that both collisions recur. Every read and every cycle's `irq` is compared against a bench model built from the requirements.

// File: rtl/mcec_pkg.sv
package mcec_pkg;
  localparam int NUM_CNT = 4;
  localparam int IDX_W   = 2;
  localparam int SEL_W   = 8;
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int SEL_LSB = 24;

  typedef struct packed {
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] clr;
  } cntCmdT;
endpackage

// File: rtl/mcec_ctrl.sv
module mcec_ctrl
  import mcec_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_EVT = 64,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wrData,
  input  logic [NUM_EVT-1:0]       evtStrobe,
  input  logic [NUM_CNT*CNT_W-1:0] cntBus,
  input  logic [NUM_CNT-1:0]       wrapVec,
  output cntCmdT                   cmd,
  output logic [31:0]              rdData,
  output logic                     irq,
  output logic                     en0
);
  localparam int PAD_W = 1 << SEL_W;

  logic [NUM_CNT-1:0] enQ, ovfQ, wrHit, accept, selHit;
  logic [SEL_W-1:0]   selQ [NUM_CNT];
  logic [PAD_W-1:0]   evtPad;
  logic               runAll, isCtrl, isCnt;
  logic [IDX_W-1:0]   idx;
  logic [31:0]        rdMux;

  assign evtPad = PAD_W'(evtStrobe);
  assign idx    = addr[IDX_W+1:2];
  assign isCtrl = (addr[ADDR_W-1:5] == '0) && (addr[4:2] < 3'(NUM_CNT)) && (addr[1:0] == 2'b00);
  assign isCnt  = (addr[ADDR_W-1:5] == (ADDR_W-5)'(1)) && (addr[4:2] < 3'(NUM_CNT)) && (addr[1:0] == 2'b00);
  // the timebase gates every counter: enabled and not frozen
  assign runAll = enQ[0] & ~ovfQ[0];

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      wrHit[i]   = wrEn && isCtrl && (idx == IDX_W'(i));
      // counter 0 cannot be re-enabled while it is still enabled
      accept[i]  = wrHit[i] && !((i == 0) && enQ[0] && wrData[EN_BIT]);
      selHit[i]  = (selQ[i] != '0) && (int'(selQ[i]) < NUM_EVT) && evtPad[selQ[i]];
      cmd.inc[i] = (i == 0) ? runAll : (runAll && enQ[i] && selHit[i]);
      cmd.clr[i] = accept[i] && wrData[CLR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ  <= '0;
      ovfQ <= '0;
      for (int i = 0; i < NUM_CNT; i++) selQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (accept[i]) begin
          enQ[i]  <= wrData[EN_BIT];
          selQ[i] <= wrData[SEL_LSB +: SEL_W];
          if (wrData[CLR_BIT] || !wrData[EN_BIT]) ovfQ[i] <= 1'b0;
          else if (wrapVec[i]) ovfQ[i] <= 1'b1;
        end else if (wrapVec[i]) begin
          ovfQ[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (isCtrl)
      rdMux = {selQ[idx], 21'b0, enQ[idx], 1'b0, ovfQ[idx]};
    else if (isCnt)
      rdMux = 32'(cntBus[idx*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  assign irq = ovfQ[0];
  assign en0 = enQ[0];
endmodule

// File: rtl/mcec_datapath.sv
module mcec_datapath
  import mcec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cntCmdT                   cmd,
  output logic [NUM_CNT*CNT_W-1:0] cntBus,
  output logic [NUM_CNT-1:0]       wrapVec
);
  logic [CNT_W-1:0] cntQ [NUM_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CNT; i++) cntQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (cmd.clr[i])      cntQ[i] <= '0;
        else if (cmd.inc[i]) cntQ[i] <= cntQ[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gLane
    assign cntBus[g*CNT_W +: CNT_W] = cntQ[g];
    assign wrapVec[g] = cmd.inc[g] && (cntQ[g] == '1);
  end
endmodule

// File: rtl/mc_event_counter.sv
module mc_event_counter
  import mcec_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_EVT = 64,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_EVT-1:0] evtStrobe,
  output logic               irq
);
  cntCmdT                   cmd;
  logic [NUM_CNT*CNT_W-1:0] cntBus;
  logic [NUM_CNT-1:0]       wrapVec;
  logic                     en0;

  mcec_ctrl #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .evtStrobe(evtStrobe), .cntBus(cntBus), .wrapVec(wrapVec),
    .cmd(cmd), .rdData(rdData), .irq(irq), .en0(en0)
  );

  mcec_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cntBus(cntBus), .wrapVec(wrapVec)
  );
endmodule

// File: rtl/mcec_checker.sv
module mcec_checker
  import mcec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wrEn,
  input logic                     irq,
  input logic                     en0,
  input logic [NUM_CNT*CNT_W-1:0] cntBus
);
  logic [CNT_W-1:0] cnt0;
  assign cnt0 = cntBus[CNT_W-1:0];

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wrEn) |=> $stable(cntBus));

  // R3
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && !irq && !wrEn) |=> (cnt0 == CNT_W'($past(cnt0) + 1'b1)));

  // R7
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !wrEn) |=> $stable(cntBus));

  // R6
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt0 == '0));

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wrEn));
endmodule

bind mc_event_counter mcec_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .irq(irq), .en0(en0), .cntBus(cntBus)
);

// File: tb/mc_event_counter_tb_top.sv
module mc_event_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int NUM_EVT    = 64;
  localparam int unsigned MAXV = (1 << CNT_W) - 1;
  localparam logic [NUM_EVT-1:0] ALL1 = '1;

  logic               clk = 1'b0, rst_n = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]         addr = '0;
  logic [31:0]        wrData = '0;
  logic [31:0]        rdData;
  logic [NUM_EVT-1:0] evt = '0;
  logic               irq;

  int checks = 0, errors = 0;
  string curTag = "R1";

  int unsigned mCnt [4];
  bit          mEn  [4];
  bit [7:0]    mSel [4];
  bit          mOvf [4];
  bit [31:0]   expRd;

  mc_event_counter #(.ADDR_W(8), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtStrobe(evt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [31:0] regVal(bit [7:0] a);
    int i = int'(a[3:2]);
    if (a[7:5] == 3'd0 && !a[4] && a[1:0] == 2'b00) return {mSel[i], 21'b0, mEn[i], 1'b0, mOvf[i]};
    if (a[7:5] == 3'd1 && !a[4] && a[1:0] == 2'b00) return mCnt[i];
    return 32'h0;
  endfunction

  function automatic bit evHit(int n, logic [NUM_EVT-1:0] e);
    return (mSel[n] != 0) && (int'(mSel[n]) < NUM_EVT) && e[mSel[n][5:0]];
  endfunction

  // reference model of the requirements, one update per clock edge
  always @(posedge clk) begin
    bit run, en0Old;
    int i;
    if (!rst_n) begin
      for (int n = 0; n < 4; n++) begin mCnt[n] = 0; mEn[n] = 0; mSel[n] = 0; mOvf[n] = 0; end
      expRd = 0;
    end else begin
      if (rdEn) expRd = regVal(addr);
      run = mEn[0] && !mOvf[0];
      en0Old = mEn[0];
      for (int n = 0; n < 4; n++) begin
        if (run && (n == 0 || (mEn[n] && evHit(n, evt)))) begin
          if (mCnt[n] == MAXV) begin mCnt[n] = 0; mOvf[n] = 1; end
          else mCnt[n] = mCnt[n] + 1;
        end
      end
      if (wrEn && addr[7:5] == 3'd0 && !addr[4] && addr[1:0] == 2'b00) begin
        i = int'(addr[3:2]);
        if (!(i == 0 && en0Old && wrData[2])) begin
          mEn[i] = wrData[2];
          mSel[i] = wrData[31:24];
          if (wrData[1]) begin mCnt[i] = 0; mOvf[i] = 0; end
          if (!wrData[2]) mOvf[i] = 0;
        end
      end
    end
  end

  task automatic chk(bit [31:0] act, bit [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, bit [7:0] a, bit [31:0] d, logic [NUM_EVT-1:0] e);
    wrEn = w; rdEn = r; addr = a; wrData = d; evt = e;
    @(posedge clk);
    @(negedge clk);
    if (r) chk(rdData, expRd, {curTag, " read"});
    chk(32'(irq), 32'(mOvf[0]), {curTag, " irq (R6)"});
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, logic [NUM_EVT-1:0] e = '0);
    step(1, 0, a, d, e);
  endtask

  task automatic rd(bit [7:0] a);
    step(0, 1, a, 0, '0);
  endtask

  task automatic idle(int n, logic [NUM_EVT-1:0] e);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, e);
  endtask

  task automatic readAllCounts();
    for (int k = 0; k < 4; k++) rd(8'(32'h20 + 4*k));
  endtask

  task automatic restart0();
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h6);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    curTag = "R1";
    for (int a = 0; a < 12; a++) begin
      rd(8'(a * 4));
      chk(rdData, 32'h0, "R1 reset literal");
    end

    // R2: map, layout, self-clearing clear bit, unmapped addresses
    curTag = "R2";
    wr(8'h04, 32'h0400_0006);
    rd(8'h04);
    chk(rdData, 32'h0400_0004, "R2 ctrl layout literal");
    rd(8'h10);
    chk(rdData, 32'h0, "R2 unmapped literal");
    rd(8'h30);
    chk(rdData, 32'h0, "R2 unmapped literal");

    // R3: cycle counter ignores its select code and the strobes
    curTag = "R3";
    wr(8'h00, 32'h0000_0006);
    idle(9, '0);
    rd(8'h20);
    rd(8'h20);

    // R4: event selection, including code 0 and out-of-range codes
    curTag = "R4";
    restart0();
    wr(8'h04, 32'h0500_0006);
    wr(8'h08, 32'h0000_0006);
    wr(8'h0C, 32'h2a00_0006);
    for (int k = 0; k < 20; k++) begin
      logic [NUM_EVT-1:0] e = '0;
      e[5] = 1'($urandom);
      e[42] = 1'($urandom);
      e[0] = 1'b1;
      step(0, 0, 0, 0, e);
    end
    readAllCounts();
    wr(8'h08, 32'h7f00_0006);
    idle(6, ALL1);
    rd(8'h28);

    // R5: event counter wraps silently and keeps going
    curTag = "R5";
    restart0();
    wr(8'h04, 32'h0500_0006);
    idle(40, ALL1);
    restart0();
    idle(30, ALL1);
    rd(8'h04);
    rd(8'h24);
    chk(32'(irq), 32'h0, "R5 no irq literal");

    // R6: cycle counter wrap freezes everything
    curTag = "R6";
    idle(70, ALL1);
    readAllCounts();
    idle(5, ALL1);
    readAllCounts();
    rd(8'h00);

    // R9: re-enable while enabled ignored; zero write releases irq
    curTag = "R9";
    wr(8'h00, 32'h0000_0006, ALL1);
    rd(8'h00);
    wr(8'h00, 32'h0, ALL1);
    chk(32'(irq), 32'h0, "R9 irq released literal");
    wr(8'h00, 32'h0000_0006, ALL1);
    idle(5, ALL1);
    readAllCounts();

    // R7: disabled timebase halts all counters
    curTag = "R7";
    wr(8'h00, 32'h0);
    idle(10, ALL1);
    readAllCounts();

    // R8: clear colliding with increment and with wrap
    curTag = "R8";
    wr(8'h00, 32'h6);
    wr(8'h04, 32'h0500_0006);
    idle(10, ALL1);
    wr(8'h04, 32'h0500_0006, ALL1);
    rd(8'h24);
    for (int k = 0; k < 300; k++) begin
      if (mCnt[1] == MAXV && mEn[0] && !mOvf[0]) break;
      if (mOvf[0] || mCnt[0] == MAXV) restart0();
      else step(0, 0, 0, 0, ALL1);
    end
    wr(8'h04, 32'h0500_0006, ALL1);
    rd(8'h04);
    chk(rdData, 32'h0500_0004, "R8 clear beats wrap literal");
    rd(8'h24);

    // random phase, all requirements against the model
    curTag = "R4 random";
    for (int k = 0; k < 4000; k++) begin
      logic [NUM_EVT-1:0] e = {$urandom, $urandom};
      int unsigned r = $urandom % 10;
      bit [7:0] codes [7] = '{8'h00, 8'h04, 8'h05, 8'h2a, 8'h31, 8'h37, 8'h50};
      if (r < 2) begin
        bit [31:0] d = {codes[$urandom % 7], 21'b0, 3'($urandom)};
        step(1, 0, 8'(4 * ($urandom % 4)), d, e);
      end else if (r < 6) begin
        step(0, 1, 8'(4 * ($urandom % 13)), 0, e);
      end else begin
        step(0, 0, 0, 0, e);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule